// File: doc/BRIEF.md
# Even/Odd Byte Bank Controller

This block connects a 16-bit data path to a byte-addressed memory that is built from two 8-bit banks. Bytes at even addresses live in the low bank, which carries the lower data lane (bits 7..0). Bytes at odd addresses live in the high bank, which carries the upper lane (bits 15..8). A requester presents a 20-bit byte address, a size flag (byte or word), a read/write flag and a one-cycle request strobe. The controller drives two active-low bank selects. One is a copy of address bit 0 and enables the low bank. The other is the bus-high-enable and enables the high bank. The controller also moves data onto the right byte lanes and assembles the read result.

An aligned word uses both banks in a single access. A word at an odd address is split into two byte accesses. The first access reads or writes the odd byte on the high lane at the given address. The second access handles the next byte, which is even, on the low lane at the address plus one. The bytes are swapped so that the result still holds the lower-addressed byte in bits 7..0.

Both banks are modelled inside the block as synchronous arrays with `2**BANK_AW` bytes each. The bank index is taken from address bits `BANK_AW..1`, so the upper address bits alias. A busy/done pair tells the requester when the one-access or two-access sequence has finished.

Top module: `dual_bank_ctrl`

## Requirements
- R1: After reset, `busy` = 0, `done` = 0, `bhe_n` = 1, `a0_sel` = 1 and `rdata` = 0.
- R2: Whenever `busy` is 0, both selects are 1 (`bhe_n` = 1, `a0_sel` = 1) and neither bank is accessed.
- R3: A byte access at an even address makes exactly one access with `a0_sel` = 0 and `bhe_n` = 1. A write stores `wdata[7:0]`. A read returns the byte in `rdata[7:0]` with `rdata[15:8]` = 0.
- R4: A byte access at an odd address makes exactly one access with `a0_sel` = 1 and `bhe_n` = 0. A write stores `wdata[7:0]` into the odd byte. A read returns the odd byte shifted down into `rdata[7:0]` with `rdata[15:8]` = 0.
- R5: A word access at an even address A makes one access with `a0_sel` = 0 and `bhe_n` = 0. Bits 7..0 of the data are byte A, and bits 15..8 are byte A+1.
- R6: A word access at an odd address A makes two accesses.
  - The first has `a0_sel` = 1, `bhe_n` = 0 and `acc_addr` = A.
  - The second has `a0_sel` = 0, `bhe_n` = 1 and `acc_addr` = A+1.
  - Bits 7..0 of the data are byte A, and bits 15..8 are byte A+1.
- R7: A request is accepted on a clock edge where `req` = 1 and `busy` = 0. From the next cycle, `busy` stays 1 up to and including the cycle where `done` is 1. `done` is a one-cycle pulse in the 2nd cycle after acceptance for a one-access transfer and in the 3rd cycle for a split transfer. `rdata` is valid for a read while `done` is 1.
- R8: `req` and the other request inputs are ignored while `busy` = 1. No memory byte changes because of them.
- R9: A byte write leaves the byte in the other bank at the neighbouring address unchanged.
- R10: The address for the second access of a split word wraps modulo 2^20, so a word at 0xFFFFF uses byte 0 as its upper byte. Addresses that differ only above bit `BANK_AW` refer to the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Request strobe, taken when not busy |
| wr | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = 16-bit word, 0 = byte |
| addr | input | 20 | Byte address |
| wdata | input | 16 | Write data; bits 7..0 are the lower-addressed byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer finishes |
| rdata | output | 16 | Read result, valid while done |
| bhe_n | output | 1 | Active-low bus-high-enable, selects the odd bank |
| a0_sel | output | 1 | Address bit 0 of the current access, active-low select of the even bank |
| acc_addr | output | 20 | Byte address of the current access |

## Verification
The embedded assertions cover the handshake rules on every cycle:
- both selects are high whenever the block is idle;
- at least one select is low during an access;
- `done` is a single-cycle pulse and `busy` rises after acceptance;
- the latched request stays put while busy;
- an odd-bank first access is always followed by an even-bank access or by completion.

Whether the right byte lands in the right bank, whether bytes are swapped for odd words, whether partner bytes stay intact, whether the address wraps, and whether intruding requests are ignored can only be shown by the bench scenarios. The bench compares every read against a flat byte-array model.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC1 = 2'd1,
    ST_ACC2 = 2'd2,
    ST_DONE = 2'd3
  } dbc_state_e;

  typedef enum logic [1:0] {
    K_BYTE_EVEN = 2'd0,
    K_BYTE_ODD  = 2'd1,
    K_WORD_EVEN = 2'd2,
    K_WORD_ODD  = 2'd3
  } dbc_kind_e;
endpackage

// File: rtl/dbc_bank.sv
module dbc_bank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] dout_q;
  logic          wr_en;
  logic          rd_en;

  assign wr_en = cs && we;
  assign rd_en = cs && !we;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[idx] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (rd_en) begin
      dout_q <= mem[idx];
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/dbc_sequencer.sv
module dbc_sequencer
  import dbc_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              bhe_n,
  output logic              a0_sel,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_we,
  output logic              wr_q,
  output dbc_kind_e         kind_q
);
  dbc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  dbc_kind_e         kind_d;

  assign accept = (state_q == ST_IDLE) && req;

  always_comb begin
    unique case ({word, addr[0]})
      2'b00:   kind_d = K_BYTE_EVEN;
      2'b01:   kind_d = K_BYTE_ODD;
      2'b10:   kind_d = K_WORD_EVEN;
      default: kind_d = K_WORD_ODD;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ACC1;
      ST_ACC1: state_d = (kind_q == K_WORD_ODD) ? ST_ACC2 : ST_DONE;
      ST_ACC2: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      kind_q <= K_BYTE_EVEN;
    end else if (accept) begin
      addr_q <= addr;
      wr_q   <= wr;
      kind_q <= kind_d;
    end
  end

  always_comb begin
    bhe_n  = 1'b1;
    a0_sel = 1'b1;
    unique case (state_q)
      ST_ACC1: begin
        unique case (kind_q)
          K_BYTE_EVEN: begin a0_sel = 1'b0; bhe_n = 1'b1; end
          K_BYTE_ODD:  begin a0_sel = 1'b1; bhe_n = 1'b0; end
          K_WORD_EVEN: begin a0_sel = 1'b0; bhe_n = 1'b0; end
          default:     begin a0_sel = 1'b1; bhe_n = 1'b0; end
        endcase
      end
      ST_ACC2: begin
        a0_sel = 1'b0;
        bhe_n  = 1'b1;
      end
      default: begin
        a0_sel = 1'b1;
        bhe_n  = 1'b1;
      end
    endcase
  end

  assign acc_addr = (state_q == ST_ACC2) ? addr_q + ADDR_W'(1) : addr_q;
  assign acc_we   = wr_q && ((state_q == ST_ACC1) || (state_q == ST_ACC2));
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);

  // R2
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bhe_n && a0_sel));

  // R3
  active_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> !(bhe_n && a0_sel));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (busy && !done));

  // R6
  split_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && a0_sel && !bhe_n) |=> (done || (!a0_sel && bhe_n)));

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(wr_q) && $stable(kind_q)));
endmodule

// File: rtl/dbc_lane_steer.sv
module dbc_lane_steer
  import dbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic [15:0] wdata,
  input  dbc_kind_e   kind_q,
  input  logic        wr_q,
  input  logic        done,
  input  logic [7:0]  lo_dout,
  input  logic [7:0]  hi_dout,
  output logic [7:0]  lo_din,
  output logic [7:0]  hi_din,
  output logic [15:0] rdata
);
  logic [15:0] wdata_q;
  logic [15:0] asm_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (accept) begin
      wdata_q <= wdata;
    end
  end

  assign lo_din = (kind_q == K_WORD_ODD)  ? wdata_q[15:8] : wdata_q[7:0];
  assign hi_din = (kind_q == K_WORD_EVEN) ? wdata_q[15:8] : wdata_q[7:0];

  always_comb begin
    unique case (kind_q)
      K_BYTE_EVEN: asm_data = {8'h00, lo_dout};
      K_BYTE_ODD:  asm_data = {8'h00, hi_dout};
      K_WORD_EVEN: asm_data = {hi_dout, lo_dout};
      default:     asm_data = {lo_dout, hi_dout};
    endcase
  end

  assign rdata = (done && !wr_q) ? asm_data : 16'h0000;

  // R3
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (kind_q == K_BYTE_EVEN || kind_q == K_BYTE_ODD)) |-> (rdata[15:8] == 8'h00));
endmodule

// File: rtl/dual_bank_ctrl.sv
module dual_bank_ctrl
  import dbc_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BANK_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rdata,
  output logic              bhe_n,
  output logic              a0_sel,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int NUM_BANKS = 2;

  logic       rst_s1_q, rst_s2_q;
  logic       accept, acc_we, wr_q;
  dbc_kind_e  kind_q;
  logic [BANK_AW-1:0] bank_idx;
  logic [NUM_BANKS-1:0] bank_cs;
  logic [7:0] bank_din  [NUM_BANKS];
  logic [7:0] bank_dout [NUM_BANKS];
  logic [7:0] lo_din, hi_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  dbc_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .req      (req),
    .wr       (wr),
    .word     (word),
    .addr     (addr),
    .accept   (accept),
    .busy     (busy),
    .done     (done),
    .bhe_n    (bhe_n),
    .a0_sel   (a0_sel),
    .acc_addr (acc_addr),
    .acc_we   (acc_we),
    .wr_q     (wr_q),
    .kind_q   (kind_q)
  );

  assign bank_idx   = acc_addr[BANK_AW:1];
  assign bank_cs[0] = !a0_sel;
  assign bank_cs[1] = !bhe_n;
  assign bank_din[0] = lo_din;
  assign bank_din[1] = hi_din;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    dbc_bank #(.AW(BANK_AW), .DW(8)) u_bank (
      .clk   (clk),
      .rst_n (rst_s2_q),
      .cs    (bank_cs[g]),
      .we    (acc_we),
      .idx   (bank_idx),
      .din   (bank_din[g]),
      .dout  (bank_dout[g])
    );
  end

  dbc_lane_steer u_steer (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .accept  (accept),
    .wdata   (wdata),
    .kind_q  (kind_q),
    .wr_q    (wr_q),
    .done    (done),
    .lo_dout (bank_dout[0]),
    .hi_dout (bank_dout[1]),
    .lo_din  (lo_din),
    .hi_din  (hi_din),
    .rdata   (rdata)
  );
endmodule

// File: tb/dual_bank_ctrl_tb.sv
module dual_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_AW    = 8;
  localparam int MSIZE      = 2 << BANK_AW;

  logic        clk, rst_n, req, wr, word;
  logic [19:0] addr, acc_addr;
  logic [15:0] wdata, rdata;
  logic        busy, done, bhe_n, a0_sel;

  dual_bank_ctrl #(.ADDR_W(20), .BANK_AW(BANK_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .word(word), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .bhe_n(bhe_n),
    .a0_sel(a0_sel), .acc_addr(acc_addr)
  );

  logic [7:0]  model [MSIZE];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  bit          cur_rd;
  int          checks, fails;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int mi(input logic [19:0] a);
    return int'(a[BANK_AW:0]);
  endfunction

  // monitor: compare completed reads with the scoreboard
  always @(negedge clk) begin
    if (rst_n && done && cur_rd) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected read", 32'(rdata), 32'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata == e, t, 32'(rdata), 32'(e));
      end
    end
  end

  task automatic do_op(input bit w, input bit wd, input logic [19:0] a,
                       input logic [15:0] d, input string rq, input bit intrude,
                       input logic [19:0] ia);
    logic [19:0] a1;
    bit split;
    bit exp_a0, exp_bhe;
    a1 = a + 20'd1;
    split = wd && a[0];
    @(negedge clk);
    // R2 idle selects
    chk(!busy && bhe_n && a0_sel, "R2 idle", {29'd0, busy, bhe_n, a0_sel}, 32'h3);
    cur_rd = !w;
    if (!w) begin
      if (wd) exp_q.push_back({model[mi(a1)], model[mi(a)]});
      else    exp_q.push_back({8'h00, model[mi(a)]});
      tag_q.push_back(rq);
    end else begin
      model[mi(a)] = d[7:0];
      if (wd) model[mi(a1)] = d[15:8];
    end
    req = 1'b1; wr = w; word = wd; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    if (intrude) begin
      req = 1'b1; wr = 1'b1; word = 1'b1; addr = ia; wdata = 16'hDEAD;
    end
    exp_a0  = wd ? a[0] : a[0];
    exp_bhe = wd ? 1'b0 : !a[0];
    chk(a0_sel == exp_a0 && bhe_n == exp_bhe, {rq, " first access selects"},
        {30'd0, a0_sel, bhe_n}, {30'd0, exp_a0, exp_bhe});
    chk(acc_addr == a, {rq, " first access address"}, 32'(acc_addr), 32'(a));
    chk(busy && !done, "R7 busy after accept", {30'd0, busy, done}, 32'h2);
    if (split) begin
      @(negedge clk);
      chk(!a0_sel && bhe_n && !done, "R6 second access selects",
          {29'd0, a0_sel, bhe_n, done}, 32'h2);
      chk(acc_addr == a1, "R6 second access address", 32'(acc_addr), 32'(a1));
    end
    @(negedge clk);
    chk(done && busy, "R7 done timing", {30'd0, done, busy}, 32'h3);
    req = 1'b0;
  endtask

  task automatic rd(input bit wd, input logic [19:0] a, input string rq);
    do_op(1'b0, wd, a, 16'h0, rq, 1'b0, 20'h0);
  endtask

  task automatic wt(input bit wd, input logic [19:0] a, input logic [15:0] d, input string rq);
    do_op(1'b1, wd, a, d, rq, 1'b0, 20'h0);
  endtask

  initial begin
    checks = 0; fails = 0; cur_rd = 1'b0;
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; word = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && bhe_n && a0_sel && rdata == 16'h0, "R1 reset",
        {12'd0, rdata, busy, done, bhe_n, a0_sel}, 32'h3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && bhe_n && a0_sel, "R1 after release",
        {29'd0, busy, done, bhe_n, a0_sel}, 32'h3);

    for (int i = 0; i < MSIZE/2; i++) begin
      logic [7:0] b;
      b = 8'(i);
      wt(1'b1, 20'(2*i), {b ^ 8'hA5, b}, "R5 init write");
    end

    rd(1'b1, 20'h00010, "R5 even word read");
    rd(1'b1, 20'hA31FE, "R5 even word read aliased");
    rd(1'b1, 20'h00021, "R6 odd word read");
    rd(1'b1, 20'h0017F, "R6 odd word read");
    rd(1'b0, 20'h00044, "R3 even byte read");
    rd(1'b0, 20'h00045, "R4 odd byte read");

    wt(1'b0, 20'h00061, 16'hFF3C, "R4 odd byte write");
    rd(1'b1, 20'h00060, "R9 neighbour kept after odd byte write");
    wt(1'b0, 20'h00070, 16'hEE81, "R3 even byte write");
    rd(1'b1, 20'h00070, "R9 neighbour kept after even byte write");
    rd(1'b0, 20'h00071, "R9 odd byte intact");

    wt(1'b1, 20'h00093, 16'h7B2D, "R6 odd word write");
    rd(1'b1, 20'h00092, "R6 odd word write low half");
    rd(1'b1, 20'h00094, "R6 odd word write high half");
    rd(1'b1, 20'h00093, "R6 odd word readback");

    wt(1'b1, 20'hFFFFF, 16'hC45A, "R10 wrap write");
    rd(1'b0, 20'h00000, "R10 wrap byte zero");
    rd(1'b0, 20'hFFFFF, "R10 top byte");
    rd(1'b1, 20'hFFFFF, "R10 wrap word read");
    rd(1'b1, 20'h7FE00, "R10 alias of byte zero");

    do_op(1'b1, 1'b0, 20'h000B0, 16'h0011, "R8 write with intrusion", 1'b1, 20'h000C0);
    rd(1'b1, 20'h000C0, "R8 intruding request ignored");
    do_op(1'b0, 1'b1, 20'h000D1, 16'h0000, "R8 split read with intrusion", 1'b1, 20'h000D4);
    rd(1'b1, 20'h000D4, "R8 intruding request ignored split");

    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int k = 0; k < 300; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[0]) wt(lf[1], {lf[15:12], 7'h0, lf[10:2]}, {lf[7:0], lf[15:8]}, "R5 random write");
        else       rd(lf[1], {lf[15:12], 7'h0, lf[10:2]}, "R6 random read");
      end
    end

    @(negedge clk);
    chk(exp_q.size() == 0, "R7 all reads completed", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule